// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

This block takes a stream of instruction bytes, one per clock over a valid/ready handshake. It gathers each instruction from its bytes: an opcode, an optional prefix page byte, and up to two immediate bytes. When the last byte of an instruction arrives, it emits one registered record. The record carries the instruction class, the raw operand fields, the condition, the immediate value assembled low byte first, and the length. It also carries a computed address for relative jumps, absolute jumps and calls, restart vectors and high-page accesses.

The caller presents the start address of each instruction on `start_addr_i` together with its first byte. The decoder samples the address only on that byte. A downstream stage that holds `out_ready_i` low stalls the input. Reset throws away any instruction that is only partly gathered.

Top module: `instr_decoder`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1. An asserted reset discards a partly gathered instruction, so the next accepted byte is decoded as a fresh opcode.
- R2: Length is 3 for 00pp0001, 0x08, 0xC3, 0xCD, 0xEA, 0xFA, 110cc010 and 110cc100. Length is 2 for 0xCB, 0x10, 0x18, 001cc000, 00rrr110, 11ooo110, 0xE0, 0xF0, 0xE8 and 0xF8. Every other opcode has length 1. `out_imm_o` is {third byte, second byte} for length 3, {0x00, second byte} for length 2, and 0 for length 1.
- R3: Opcodes 0x40–0x7F give class 1 (move), with `out_x_o` = bits 5:3 (destination) and `out_z_o` = bits 2:0 (source). Operand index 6 means memory at HL. Opcode 0x76 instead gives class 2 (halt) with length 1.
- R4: Opcodes 0x80–0xBF give class 3 (ALU on a register), with `out_x_o` = operation (0 add … 7 compare) and `out_z_o` = source. Opcodes 11ooo110 give class 4 (ALU with immediate), with `out_x_o` = ooo and length 2.
- R5: Opcode 0xCB followed by byte p gives class 5 and length 2. `out_kind_o` = p[7:6] (0 rotate/shift/swap, 1 bit test, 2 bit reset, 3 bit set), `out_x_o` = p[5:3] and `out_z_o` = p[2:0].
- R6: `out_pair_o` = opcode bits 5:4 (BC, DE, HL, SP as 0–3). Pop 11pp0001 and push 11pp0101 give class 12, with `out_kind_o` = 0 for pop and 1 for push. `out_af_o` is 1 only for a push or pop with pair code 3.
- R7: `out_cond_o` = opcode bits 4:3 (NZ, Z, NC, C as 0–3). `out_has_cond_o` is 1 for 001cc000, 110cc000, 110cc010 and 110cc100. It is 0 for the unconditional 0x18, 0xC9, 0xD9, 0xC3 and 0xCD.
- R8: Relative jumps give class 6 and `out_target_o` = start + 2 + sign-extended displacement, modulo 2^16.
- R9: Restart 11nnn111 gives class 10 and `out_target_o` = nnn×8.
- R10: Opcodes 0xE0, 0xF0, 0xE2 and 0xF2 give class 11. `out_kind_o[1]` is 1 for a read (0xF0, 0xF2), and `out_kind_o[0]` is 1 when the offset is register C. The target is 0xFF00 + immediate for 0xE0/0xF0, and 0xFF00 for 0xE2/0xF2, which have length 1.
- R11: Absolute jumps (class 7) and calls (class 8) give `out_target_o` = the assembled 16-bit immediate. Returns, including 0xC9, 0xD9 and 110cc000, give class 9.
- R12: Opcodes 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC and 0xFD set `out_illegal_o` and give class 13 and length 1. The following byte is decoded as a new opcode.
- R13: `in_ready_o` is low exactly while a record is held with `out_ready_i` low. While stalled, the record stays stable. With the output free, one byte is accepted per cycle and the record appears the cycle after its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte offered |
| in_byte_i | input | 8 | Instruction byte |
| start_addr_i | input | 16 | Address of the instruction, sampled with its first byte |
| in_ready_o | output | 1 | Byte can be accepted |
| out_valid_o | output | 1 | Record valid |
| out_ready_i | input | 1 | Record accepted |
| out_class_o | output | 4 | Instruction class code |
| out_x_o | output | 3 | Bits 5:3 of the key byte |
| out_z_o | output | 3 | Bits 2:0 of the key byte |
| out_pair_o | output | 2 | Register-pair code |
| out_af_o | output | 1 | Pair code 3 means AF |
| out_cond_o | output | 2 | Condition code |
| out_has_cond_o | output | 1 | Instruction is conditional |
| out_kind_o | output | 2 | Sub-kind (prefix group, push/pop, high-page form) |
| out_imm_o | output | 16 | Assembled immediate |
| out_len_o | output | 2 | Length in bytes |
| out_target_o | output | 16 | Computed address |
| out_illegal_o | output | 1 | Undefined opcode |

## Verification
The assertions assume that `out_ready_i` and `in_valid_i` are free to change, but that a producer keeps `start_addr_i` meaningful on the first byte of each instruction. They also assume reset is applied before any traffic. They check that a held record never changes and that illegal, halt and prefix records carry their fixed lengths. They also check that restart targets stay on 8-byte boundaries below 0x40. The stimulus drives the start address with every byte of an instruction and changes inputs only on falling edges. It exercises stalls by lowering `out_ready_i` while keeping a byte offered, so the stall condition the assertions guard is reached without breaking the handshake.

// File: rtl/idec_pkg.sv
package idec_pkg;
  parameter int unsigned AW = 16;
  localparam int unsigned BW = 8;
  localparam logic [AW-1:0] HIGH_BASE = {{(AW-BW){1'b1}}, {BW{1'b0}}};

  typedef enum logic [3:0] {
    CL_MISC    = 4'd0,
    CL_MOVE    = 4'd1,
    CL_HALT    = 4'd2,
    CL_ALU     = 4'd3,
    CL_ALU_IMM = 4'd4,
    CL_PREFIX  = 4'd5,
    CL_JR      = 4'd6,
    CL_JP      = 4'd7,
    CL_CALL    = 4'd8,
    CL_RET     = 4'd9,
    CL_RST     = 4'd10,
    CL_HIGH    = 4'd11,
    CL_STACK   = 4'd12,
    CL_ILLEGAL = 4'd13
  } iclass_e;
endpackage

// File: rtl/instr_len.sv
module instr_len
  import idec_pkg::*;
(
  input  logic [BW-1:0] op_i,
  output logic [1:0]    len_o,
  output logic          illegal_o
);
  always_comb begin
    illegal_o = op_i inside {8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB,
                             8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD};
    len_o = 2'd1;
    if (illegal_o)
      len_o = 2'd1;
    else if (op_i inside {8'hCB, 8'h10, 8'h18, 8'hE0, 8'hF0, 8'hE8, 8'hF8})
      len_o = 2'd2;
    else if (op_i[7:6] != 2'b01 && op_i[7:6] != 2'b10 && op_i[2:0] == 3'b110)
      len_o = 2'd2;                          // 00rrr110 and 11ooo110
    else if (op_i[7:5] == 3'b001 && op_i[2:0] == 3'b000)
      len_o = 2'd2;                          // conditional relative jump
    else if (op_i[7:6] == 2'b00 && op_i[3:0] == 4'h1)
      len_o = 2'd3;
    else if (op_i inside {8'h08, 8'hC3, 8'hCD, 8'hEA, 8'hFA})
      len_o = 2'd3;
    else if (op_i[7:5] == 3'b110 && (op_i[2:0] == 3'b010 || op_i[2:0] == 3'b100))
      len_o = 2'd3;
  end
endmodule

// File: rtl/instr_fields.sv
module instr_fields
  import idec_pkg::*;
(
  input  logic [BW-1:0] op_i,
  input  logic [BW-1:0] pre_i,
  input  logic          illegal_i,
  output iclass_e       cls_o,
  output logic [2:0]    x_o,
  output logic [2:0]    z_o,
  output logic [1:0]    pair_o,
  output logic [1:0]    cond_o,
  output logic          has_cond_o,
  output logic [1:0]    kind_o,
  output logic          af_o
);
  logic [BW-1:0] key;
  assign key    = (op_i == 8'hCB) ? pre_i : op_i;
  assign x_o    = key[5:3];
  assign z_o    = key[2:0];
  assign pair_o = op_i[5:4];
  assign cond_o = op_i[4:3];

  always_comb begin
    cls_o      = CL_MISC;
    has_cond_o = 1'b0;
    kind_o     = 2'd0;
    af_o       = 1'b0;
    if (illegal_i)                                         cls_o = CL_ILLEGAL;
    else if (op_i == 8'hCB) begin
      cls_o  = CL_PREFIX;
      kind_o = pre_i[7:6];
    end
    else if (op_i == 8'h76)                                cls_o = CL_HALT;
    else if (op_i[7:6] == 2'b01)                           cls_o = CL_MOVE;
    else if (op_i[7:6] == 2'b10)                           cls_o = CL_ALU;
    else if (op_i[7:6] == 2'b11 && op_i[2:0] == 3'b110)   cls_o = CL_ALU_IMM;
    else if (op_i == 8'h18)                                cls_o = CL_JR;
    else if (op_i[7:5] == 3'b001 && op_i[2:0] == 3'b000) begin
      cls_o = CL_JR;  has_cond_o = 1'b1;
    end
    else if (op_i == 8'hC3)                                cls_o = CL_JP;
    else if (op_i[7:5] == 3'b110 && op_i[2:0] == 3'b010) begin
      cls_o = CL_JP;  has_cond_o = 1'b1;
    end
    else if (op_i == 8'hCD)                                cls_o = CL_CALL;
    else if (op_i[7:5] == 3'b110 && op_i[2:0] == 3'b100) begin
      cls_o = CL_CALL; has_cond_o = 1'b1;
    end
    else if (op_i == 8'hC9 || op_i == 8'hD9)               cls_o = CL_RET;
    else if (op_i[7:5] == 3'b110 && op_i[2:0] == 3'b000) begin
      cls_o = CL_RET; has_cond_o = 1'b1;
    end
    else if (op_i[7:6] == 2'b11 && op_i[2:0] == 3'b111)   cls_o = CL_RST;
    else if (op_i inside {8'hE0, 8'hF0, 8'hE2, 8'hF2}) begin
      cls_o  = CL_HIGH;
      kind_o = {op_i[4], op_i[1]};             // {read, offset from C}
    end
    else if (op_i[7:6] == 2'b11 && (op_i[3:0] == 4'h1 || op_i[3:0] == 4'h5)) begin
      cls_o  = CL_STACK;
      kind_o = {1'b0, op_i[2]};
      af_o   = (op_i[5:4] == 2'd3);
    end
  end
endmodule

// File: rtl/target_calc.sv
module target_calc
  import idec_pkg::*;
(
  input  iclass_e       cls_i,
  input  logic [2:0]    vec_i,
  input  logic          c_off_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] imm_i,
  output logic [AW-1:0] target_o
);
  localparam logic [AW-1:0] STEP = AW'(2);
  logic [AW-1:0] disp;
  assign disp = {{(AW-BW){imm_i[BW-1]}}, imm_i[BW-1:0]};

  always_comb begin
    unique case (cls_i)
      CL_JR:          target_o = start_i + STEP + disp;
      CL_JP, CL_CALL: target_o = imm_i;
      CL_RST:         target_o = AW'({vec_i, 3'b000});
      CL_HIGH:        target_o = c_off_i ? HIGH_BASE
                                         : (HIGH_BASE | {{(AW-BW){1'b0}}, imm_i[BW-1:0]});
      default:        target_o = '0;
    endcase
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [7:0]    in_byte_i,
  input  logic [15:0]   start_addr_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [3:0]    out_class_o,
  output logic [2:0]    out_x_o,
  output logic [2:0]    out_z_o,
  output logic [1:0]    out_pair_o,
  output logic          out_af_o,
  output logic [1:0]    out_cond_o,
  output logic          out_has_cond_o,
  output logic [1:0]    out_kind_o,
  output logic [15:0]   out_imm_o,
  output logic [1:0]    out_len_o,
  output logic [15:0]   out_target_o,
  output logic          out_illegal_o
);
  logic [1:0]    cnt_q;
  logic [BW-1:0] op_q, b1_q;
  logic [AW-1:0] start_q;

  logic          take, done;
  logic [BW-1:0] cur_op, cur_b1;
  logic [AW-1:0] cur_start, imm;
  logic [1:0]    len;
  logic          illegal;
  iclass_e       cls;
  logic [2:0]    fx, fz;
  logic [1:0]    fpair, fcond, fkind;
  logic          fhas_cond, faf;
  logic [AW-1:0] target;

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign take       = in_valid_i & in_ready_o;
  assign cur_op     = (cnt_q == 2'd0) ? in_byte_i : op_q;
  assign cur_b1     = (cnt_q == 2'd1) ? in_byte_i : b1_q;
  assign cur_start  = (cnt_q == 2'd0) ? start_addr_i : start_q;
  assign done       = take && (cnt_q == len - 2'd1);

  always_comb begin
    unique case (len)
      2'd2:    imm = {{(AW-BW){1'b0}}, cur_b1};
      2'd3:    imm = {in_byte_i, cur_b1};
      default: imm = '0;
    endcase
  end

  instr_len u_len (.op_i(cur_op), .len_o(len), .illegal_o(illegal));

  instr_fields u_fields (
    .op_i(cur_op), .pre_i(cur_b1), .illegal_i(illegal), .cls_o(cls),
    .x_o(fx), .z_o(fz), .pair_o(fpair), .cond_o(fcond),
    .has_cond_o(fhas_cond), .kind_o(fkind), .af_o(faf)
  );

  target_calc u_tgt (
    .cls_i(cls), .vec_i(cur_op[5:3]), .c_off_i(cur_op[1]),
    .start_i(cur_start), .imm_i(imm), .target_o(target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= 2'd0;
      op_q    <= '0;
      b1_q    <= '0;
      start_q <= '0;
    end else if (take) begin
      if (done) cnt_q <= 2'd0;
      else begin
        cnt_q <= cnt_q + 2'd1;
        if (cnt_q == 2'd0) begin
          op_q    <= in_byte_i;
          start_q <= start_addr_i;
        end
        if (cnt_q == 2'd1) b1_q <= in_byte_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o    <= 1'b0;
      out_class_o    <= '0;
      out_x_o        <= '0;
      out_z_o        <= '0;
      out_pair_o     <= '0;
      out_af_o       <= 1'b0;
      out_cond_o     <= '0;
      out_has_cond_o <= 1'b0;
      out_kind_o     <= '0;
      out_imm_o      <= '0;
      out_len_o      <= '0;
      out_target_o   <= '0;
      out_illegal_o  <= 1'b0;
    end else if (done) begin
      out_valid_o    <= 1'b1;
      out_class_o    <= cls;
      out_x_o        <= fx;
      out_z_o        <= fz;
      out_pair_o     <= fpair;
      out_af_o       <= faf;
      out_cond_o     <= fcond;
      out_has_cond_o <= fhas_cond;
      out_kind_o     <= fkind;
      out_imm_o      <= imm;
      out_len_o      <= len;
      out_target_o   <= target;
      out_illegal_o  <= illegal;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  assert_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_imm_o)
      && $stable(out_target_o) && $stable(out_class_o) && $stable(out_len_o));

  assert_gather_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != 2'd3);

  assert_halt_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_class_o == CL_HALT |-> out_len_o == 2'd1);

  assert_prefix_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_class_o == CL_PREFIX |-> out_len_o == 2'd2);

  assert_rst_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_class_o == CL_RST |-> out_target_o[2:0] == 3'd0
      && out_target_o < 16'h0040);

  assert_illegal_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_illegal_o |-> out_len_o == 2'd1 && out_class_o == CL_ILLEGAL);
endmodule

// File: tb/instr_decoder_test.sv
`timescale 1ns/1ps
module instr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [15:0] start_addr = '0;
  logic        in_ready, out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  o_class;
  logic [2:0]  o_x, o_z;
  logic [1:0]  o_pair, o_cond, o_kind, o_len;
  logic        o_af, o_has_cond, o_illegal;
  logic [15:0] o_imm, o_target;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  instr_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_byte_i(in_byte),
    .start_addr_i(start_addr), .in_ready_o(in_ready), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_class_o(o_class), .out_x_o(o_x), .out_z_o(o_z),
    .out_pair_o(o_pair), .out_af_o(o_af), .out_cond_o(o_cond),
    .out_has_cond_o(o_has_cond), .out_kind_o(o_kind), .out_imm_o(o_imm),
    .out_len_o(o_len), .out_target_o(o_target), .out_illegal_o(o_illegal)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drives n bytes, then samples at the falling edge after the last one
  task automatic send(int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                      logic [15:0] sa);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_byte    = (i == 0) ? b0 : (i == 1) ? b1 : b2;
      start_addr = sa;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset_R1;
    chk("R1 valid after reset", out_valid, 0);
    chk("R1 ready after reset", in_ready, 1);
    send(1, 8'hC3, 0, 0, 16'h0);
    chk("R1 partial no record", out_valid, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send(1, 8'h00, 0, 0, 16'h0);
    chk("R1 fresh opcode valid", out_valid, 1);
    chk("R1 fresh opcode len", o_len, 1);
    chk("R1 fresh opcode class", o_class, 0);
  endtask

  task automatic t_move_R3;
    send(1, 8'h53, 0, 0, 16'h0);
    chk("R3 move class", o_class, 1);
    chk("R3 move dst", o_x, 2);
    chk("R3 move src", o_z, 3);
    send(1, 8'h76, 0, 0, 16'h0);
    chk("R3 halt class", o_class, 2);
    chk("R3 halt len", o_len, 1);
    send(1, 8'h6E, 0, 0, 16'h0);
    chk("R3 mem source index", o_z, 6);
  endtask

  task automatic t_alu_R4;
    send(1, 8'hA9, 0, 0, 16'h0);
    chk("R4 alu class", o_class, 3);
    chk("R4 alu op", o_x, 5);
    chk("R4 alu src", o_z, 1);
    send(2, 8'hFE, 8'h42, 0, 16'h0);
    chk("R4 alu imm class", o_class, 4);
    chk("R4 alu imm op", o_x, 7);
    chk("R4 alu imm value", o_imm, 16'h0042);
    chk("R4 alu imm len", o_len, 2);
  endtask

  task automatic t_prefix_R5;
    send(2, 8'hCB, 8'h37, 0, 16'h0);
    chk("R5 prefix class", o_class, 5);
    chk("R5 prefix kind", o_kind, 0);
    chk("R5 prefix op", o_x, 6);
    chk("R5 prefix operand", o_z, 7);
    chk("R5 prefix len", o_len, 2);
    send(2, 8'hCB, 8'hDE, 0, 16'h0);
    chk("R5 set kind", o_kind, 3);
    chk("R5 set bit", o_x, 3);
    chk("R5 set operand", o_z, 6);
  endtask

  task automatic t_imm_R2;
    send(3, 8'h21, 8'h34, 8'h12, 16'h0);
    chk("R2 len3", o_len, 3);
    chk("R2 little endian", o_imm, 16'h1234);
    chk("R6 pair hl", o_pair, 2);
    send(2, 8'h10, 8'h00, 0, 16'h0);
    chk("R2 stop len", o_len, 2);
    send(1, 8'h3C, 0, 0, 16'h0);
    chk("R2 len1 imm zero", o_imm, 0);
  endtask

  task automatic t_stack_R6;
    send(1, 8'hF5, 0, 0, 16'h0);
    chk("R6 push class", o_class, 12);
    chk("R6 push kind", o_kind, 1);
    chk("R6 push af", o_af, 1);
    send(1, 8'hC1, 0, 0, 16'h0);
    chk("R6 pop kind", o_kind, 0);
    chk("R6 pop pair", o_pair, 0);
    send(3, 8'h31, 8'h00, 8'h00, 16'h0);
    chk("R6 sp pair", o_pair, 3);
    chk("R6 sp not af", o_af, 0);
  endtask

  task automatic t_cond_R7;
    send(1, 8'hD8, 0, 0, 16'h0);
    chk("R11 ret class", o_class, 9);
    chk("R7 ret cond", o_cond, 3);
    chk("R7 ret has_cond", o_has_cond, 1);
    send(1, 8'hC9, 0, 0, 16'h0);
    chk("R7 plain ret", o_has_cond, 0);
    send(3, 8'hCA, 8'h00, 8'h40, 16'h0);
    chk("R7 jp cond", o_cond, 1);
    chk("R11 jp class", o_class, 7);
    chk("R11 jp target", o_target, 16'h4000);
    send(3, 8'hCD, 8'h34, 8'h12, 16'h0);
    chk("R11 call class", o_class, 8);
    chk("R11 call target", o_target, 16'h1234);
    chk("R7 call uncond", o_has_cond, 0);
  endtask

  task automatic t_jr_R8;
    send(2, 8'h18, 8'hFE, 0, 16'h1000);
    chk("R8 jr class", o_class, 6);
    chk("R8 jr back", o_target, 16'h1000);
    send(2, 8'h20, 8'h7F, 0, 16'h1000);
    chk("R8 jr forward", o_target, 16'h1081);
    chk("R7 jr nz", o_has_cond, 1);
    send(2, 8'h38, 8'h05, 0, 16'hFFFF);
    chk("R8 jr wrap", o_target, 16'h0006);
  endtask

  task automatic t_rst_R9;
    send(1, 8'hFF, 0, 0, 16'h0);
    chk("R9 rst class", o_class, 10);
    chk("R9 rst 38", o_target, 16'h0038);
    send(1, 8'hC7, 0, 0, 16'h0);
    chk("R9 rst 00", o_target, 16'h0000);
    send(1, 8'hD7, 0, 0, 16'h0);
    chk("R9 rst 10", o_target, 16'h0010);
  endtask

  task automatic t_high_R10;
    send(2, 8'hE0, 8'h44, 0, 16'h0);
    chk("R10 high class", o_class, 11);
    chk("R10 high target", o_target, 16'hFF44);
    chk("R10 high kind store", o_kind, 0);
    send(1, 8'hF2, 0, 0, 16'h0);
    chk("R10 via C len", o_len, 1);
    chk("R10 via C target", o_target, 16'hFF00);
    chk("R10 via C kind", o_kind, 3);
  endtask

  task automatic t_illegal_R12;
    send(1, 8'hDD, 0, 0, 16'h0);
    chk("R12 illegal flag", o_illegal, 1);
    chk("R12 illegal class", o_class, 13);
    chk("R12 illegal len", o_len, 1);
    send(1, 8'h00, 0, 0, 16'h0);
    chk("R12 next fresh", o_illegal, 0);
    chk("R12 next class", o_class, 0);
  endtask

  task automatic t_stall_R13;
    @(negedge clk);
    out_ready  = 1'b0;
    in_valid   = 1'b1;
    in_byte    = 8'h47;
    @(posedge clk);
    @(negedge clk);
    in_byte = 8'h80;
    chk("R13 valid", out_valid, 1);
    chk("R13 stall ready", in_ready, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13 held class", o_class, 1);
    chk("R13 held src", o_z, 7);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R13 resume class", o_class, 3);
    chk("R13 resume src", o_z, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R13 drained", out_valid, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_move_R3();
    t_alu_R4();
    t_prefix_R5();
    t_imm_R2();
    t_stack_R6();
    t_cond_R7();
    t_jr_R8();
    t_rst_R9();
    t_high_R10();
    t_illegal_R12();
    t_stall_R13();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule